// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Edge Interrupts

This block is one bank of sixteen general-purpose pins behind a small word-addressed register bus. Software can drive pins or leave them as inputs, read the sampled pin levels and pick an edge mode for each pin. Pin events are latched in a sticky status register. The bank raises an interrupt request and a separate wake-up request whenever a latched event matches the corresponding enable mask.

The data-out, interrupt-enable and wake-enable registers each have two alias addresses, one that sets bits and one that clears bits. A driver can therefore change one pin with a single write and needs no read-modify-write sequence. Pads pass through a two-flop synchroniser before the bank compares them with their previous value. A write of ones to the status register clears the selected bits. If a new event lands on a bit in the same cycle as its clear, the event is kept.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset the data-out, interrupt-enable, wake-enable, edge-select and status registers all read zero. The direction register reads 0xFFFF, so every pin is an input. irqOut, wakeOut and padOe are all low.
- R2: The pin-input register (word 1) returns the synchronised level of all sixteen pads. A pad change made before a clock edge becomes readable after two more edges.
- R3: In the direction register (word 5), a 1 makes a pin an input and a 0 makes it an output. padOe is the inverse of the direction bits, padOut carries the data-out value, and padOe changes only when the direction register is written.
- R4: Word 2 is data-out. Writing ones to word 3 sets the matching data-out bits, and writing ones to word 4 clears them. Zero bits in either alias leave their pins unchanged.
- R5: The interrupt-enable register (word 8, set alias 9, clear alias 10) and the wake-enable register (word 11, set alias 12, clear alias 13) follow the same set/clear rules as the data-out aliases.
- R6: Each pin has a two-bit edge code. 2'b10 detects rising edges, 2'b01 detects falling edges, 2'b00 detects nothing and 2'b11 detects both.
- R7: Pins 0 to 7 take their edge code from word 6 at bits [2i+1:2i]. Pins 8 to 15 take theirs from word 7 at bits [2(i-8)+1:2(i-8)].
- R8: A detected edge sets its status bit (word 14) whatever the enable bits are. The bit stays set until it is cleared, and a status bit is set only by a detected edge.
- R9: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R10: When an edge and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R11: irqOut is high exactly when some status bit has its interrupt-enable bit set. wakeOut is high exactly when some status bit has its wake-enable bit set.
- R12: A read returns its data on busRdata with busRvalid high in the cycle after busRe. busRvalid is low in every other cycle.
- R13: Word 0 reads the constant 0x00000021. All register values are zero-extended to the 32-bit bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busRvalid |
| busRvalid | output | 1 | Read data valid, one cycle after busRe |
| padIn | input | 16 | Asynchronous pad levels |
| padOut | output | 16 | Value driven onto output pins |
| padOe | output | 16 | Output enable per pin |
| irqOut | output | 1 | Aggregated interrupt request |
| wakeOut | output | 1 | Aggregated wake-up request |

## Verification
The assertions check on every cycle:
- that every status bit traces back to an earlier status bit or a detected edge;
- that a detected edge always survives a clear in the same cycle;
- that status bits stay set unless the status register is written;
- that the set and clear aliases act on padOut;
- that the output enables hold when direction is not written;
- that read-valid timing is correct;
- that neither request output rises without a status bit.

Only the bench scenarios can show the rest:
- that each edge code picks the right polarity;
- that the fields of the two edge-control words map to the right pins;
- the synchroniser latency;
- the reset values;
- that the enable masks pick the right status bits for each request output.

// File: rtl/gpio_edge_bank_pkg.sv
package gpio_edge_bank_pkg;

  // Word addresses on the register bus
  localparam int RA_ID       = 0;
  localparam int RA_PIN_IN   = 1;
  localparam int RA_OUT      = 2;
  localparam int RA_OUT_SET  = 3;
  localparam int RA_OUT_CLR  = 4;
  localparam int RA_DIR      = 5;
  localparam int RA_EDGE_LO  = 6;
  localparam int RA_EDGE_HI  = 7;
  localparam int RA_IRQ_EN   = 8;
  localparam int RA_IRQ_SET  = 9;
  localparam int RA_IRQ_CLR  = 10;
  localparam int RA_WAKE_EN  = 11;
  localparam int RA_WAKE_SET = 12;
  localparam int RA_WAKE_CLR = 13;
  localparam int RA_STAT     = 14;

  // Control to datapath strobes, at most one write strobe per cycle
  typedef struct packed {
    logic wrOut;
    logic setOut;
    logic clrOut;
    logic wrDir;
    logic wrEdgeLo;
    logic wrEdgeHi;
    logic wrIrqEn;
    logic setIrqEn;
    logic clrIrqEn;
    logic wrWake;
    logic setWake;
    logic clrWake;
    logic clrStat;
    logic rdGo;
  } strobe_t;

endpackage

// File: rtl/gpio_edge_bank_ctrl.sv
module gpio_edge_bank_ctrl
  import gpio_edge_bank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobes
);

  always_comb begin
    strobes      = '0;
    strobes.rdGo = busRe;
    if (busWe) begin
      case (busAddr)
        ADDR_W'(RA_OUT):      strobes.wrOut    = 1'b1;
        ADDR_W'(RA_OUT_SET):  strobes.setOut   = 1'b1;
        ADDR_W'(RA_OUT_CLR):  strobes.clrOut   = 1'b1;
        ADDR_W'(RA_DIR):      strobes.wrDir    = 1'b1;
        ADDR_W'(RA_EDGE_LO):  strobes.wrEdgeLo = 1'b1;
        ADDR_W'(RA_EDGE_HI):  strobes.wrEdgeHi = 1'b1;
        ADDR_W'(RA_IRQ_EN):   strobes.wrIrqEn  = 1'b1;
        ADDR_W'(RA_IRQ_SET):  strobes.setIrqEn = 1'b1;
        ADDR_W'(RA_IRQ_CLR):  strobes.clrIrqEn = 1'b1;
        ADDR_W'(RA_WAKE_EN):  strobes.wrWake   = 1'b1;
        ADDR_W'(RA_WAKE_SET): strobes.setWake  = 1'b1;
        ADDR_W'(RA_WAKE_CLR): strobes.clrWake  = 1'b1;
        ADDR_W'(RA_STAT):     strobes.clrStat  = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_edge_bank_dp.sv
module gpio_edge_bank_dp
  import gpio_edge_bank_pkg::*;
#(
  parameter int          PINS   = 16,
  parameter int          DATA_W = 32,
  parameter int          ADDR_W = 4,
  parameter logic [31:0] REV_ID = 32'h0000_0021
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic              irqOut,
  output logic              wakeOut,
  output logic [PINS-1:0]   statVec,
  output logic [PINS-1:0]   evtVec
);

  localparam int GROUP  = PINS / 2;
  localparam int EDGE_W = 2 * GROUP;

  logic [PINS-1:0]   syncA, syncB, prevB;
  logic [PINS-1:0]   dataOut, dirReg, irqEn, wakeEn, stat;
  logic [EDGE_W-1:0] edgeLo, edgeHi;
  logic [PINS-1:0]   wdPins;
  logic [EDGE_W-1:0] wdEdge;
  logic [DATA_W-1:0] rdMux;
  logic              unusedWdata;

  assign wdPins      = busWdata[PINS-1:0];
  assign wdEdge      = busWdata[EDGE_W-1:0];
  assign unusedWdata = ^busWdata[DATA_W-1:PINS];

  // Per-pin edge decode, the field location depends on the pin group
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [1:0] code;
    if (i < GROUP) begin : g_lo
      assign code = edgeLo[2*i +: 2];
    end else begin : g_hi
      assign code = edgeHi[2*(i-GROUP) +: 2];
    end
    assign evtVec[i] = (code[1] &  syncB[i] & ~prevB[i]) |
                       (code[0] & ~syncB[i] &  prevB[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut <= '0;
      dirReg  <= '1;
      edgeLo  <= '0;
      edgeHi  <= '0;
      irqEn   <= '0;
      wakeEn  <= '0;
      stat    <= '0;
    end else begin
      if (strobes.wrOut)       dataOut <= wdPins;
      else if (strobes.setOut) dataOut <= dataOut | wdPins;
      else if (strobes.clrOut) dataOut <= dataOut & ~wdPins;

      if (strobes.wrDir)    dirReg <= wdPins;
      if (strobes.wrEdgeLo) edgeLo <= wdEdge;
      if (strobes.wrEdgeHi) edgeHi <= wdEdge;

      if (strobes.wrIrqEn)       irqEn <= wdPins;
      else if (strobes.setIrqEn) irqEn <= irqEn | wdPins;
      else if (strobes.clrIrqEn) irqEn <= irqEn & ~wdPins;

      if (strobes.wrWake)       wakeEn <= wdPins;
      else if (strobes.setWake) wakeEn <= wakeEn | wdPins;
      else if (strobes.clrWake) wakeEn <= wakeEn & ~wdPins;

      // new events are ORed in after the clear, so they win
      stat <= (stat & ~(strobes.clrStat ? wdPins : '0)) | evtVec;
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(RA_ID):      rdMux = DATA_W'(REV_ID);
      ADDR_W'(RA_PIN_IN):  rdMux = DATA_W'(syncB);
      ADDR_W'(RA_OUT):     rdMux = DATA_W'(dataOut);
      ADDR_W'(RA_DIR):     rdMux = DATA_W'(dirReg);
      ADDR_W'(RA_EDGE_LO): rdMux = DATA_W'(edgeLo);
      ADDR_W'(RA_EDGE_HI): rdMux = DATA_W'(edgeHi);
      ADDR_W'(RA_IRQ_EN):  rdMux = DATA_W'(irqEn);
      ADDR_W'(RA_WAKE_EN): rdMux = DATA_W'(wakeEn);
      ADDR_W'(RA_STAT):    rdMux = DATA_W'(stat);
      default:             rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRvalid <= 1'b0;
      busRdata  <= '0;
    end else begin
      busRvalid <= strobes.rdGo;
      if (strobes.rdGo) busRdata <= rdMux;
    end
  end

  assign padOut  = dataOut;
  assign padOe   = ~dirReg;
  assign irqOut  = |(stat & irqEn);
  assign wakeOut = |(stat & wakeEn);
  assign statVec = stat;

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_bank_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic              irqOut,
  output logic              wakeOut
);

  strobe_t         strobes;
  logic [PINS-1:0] irqStat;
  logic [PINS-1:0] edgeEvt;

  gpio_edge_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWe   (busWe),
    .busRe   (busRe),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  gpio_edge_bank_dp #(.PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .busRvalid (busRvalid),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .irqOut    (irqOut),
    .wakeOut   (wakeOut),
    .statVec   (irqStat),
    .evtVec    (edgeEvt)
  );

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_edge_bank_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic              busRe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busRvalid,
  input logic [PINS-1:0]   padOut,
  input logic [PINS-1:0]   padOe,
  input logic              irqOut,
  input logic              wakeOut,
  input logic [PINS-1:0]   statVec,
  input logic [PINS-1:0]   evtVec
);

  logic            wrStat, wrSet, wrClr, wrDir;
  logic [PINS-1:0] wdPins;

  assign wrStat = busWe && (busAddr == ADDR_W'(RA_STAT));
  assign wrSet  = busWe && (busAddr == ADDR_W'(RA_OUT_SET));
  assign wrClr  = busWe && (busAddr == ADDR_W'(RA_OUT_CLR));
  assign wrDir  = busWe && (busAddr == ADDR_W'(RA_DIR));
  assign wdPins = busWdata[PINS-1:0];

  // R12: read data strobe follows a read by one cycle
  p_read_valid_r12: assert property (@(posedge clk) disable iff (!rstN)
    busRe |=> busRvalid);
  p_read_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |=> !busRvalid);

  // R8: a status bit appears only from earlier status or a detected edge
  p_stat_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statVec & ~($past(statVec) | $past(evtVec))) == '0));

  // R9: without a status write, set bits stay set
  p_stat_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    !wrStat |=> ((statVec & $past(statVec)) == $past(statVec)));

  // R10: an edge event always lands, even under a same-cycle clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statVec & $past(evtVec)) == $past(evtVec)));

  // R11: request outputs need a pending status bit
  p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statVec != '0));
  p_wake_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> (statVec != '0));

  // R4: set and clear aliases act on the driven pins
  p_out_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrSet |=> ((padOut & $past(wdPins)) == $past(wdPins)));
  p_out_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrClr |=> ((padOut & $past(wdPins)) == '0));
  p_out_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrSet || wrClr) |=> ((padOut & ~$past(wdPins)) == ($past(padOut) & ~$past(wdPins))));

  // R3: output enables move only on a direction write
  p_oe_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrDir |=> $stable(padOe));

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(
  .PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWe     (busWe),
  .busRe     (busRe),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busRvalid (busRvalid),
  .padOut    (padOut),
  .padOe     (padOe),
  .irqOut    (irqOut),
  .wakeOut   (wakeOut),
  .statVec   (irqStat),
  .evtVec    (edgeEvt)
);

// File: tb/tb_gpio_edge_bank.sv
module tb_gpio_edge_bank;

  localparam int PINS   = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int A_ID = 0, A_PIN = 1, A_OUT = 2, A_OSET = 3, A_OCLR = 4, A_DIR = 5;
  localparam int A_ELO = 6, A_EHI = 7, A_IEN = 8, A_ISET = 9, A_ICLR = 10;
  localparam int A_WEN = 11, A_WSET = 12, A_WCLR = 13, A_STAT = 14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWe = 1'b0;
  logic              busRe = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic              busRvalid;
  logic [PINS-1:0]   padIn = '0;
  logic [PINS-1:0]   padOut;
  logic [PINS-1:0]   padOe;
  logic              irqOut;
  logic              wakeOut;

  int chkCnt = 0;
  int errCnt = 0;
  logic [DATA_W-1:0] expQ[$];
  string             tagQ[$];
  logic [DATA_W-1:0] popExp;
  string             popTag;

  always #4 clk = ~clk;  // 125 MHz

  gpio_edge_bank #(.PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busRvalid(busRvalid),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .irqOut(irqOut), .wakeOut(wakeOut)
  );

  task automatic checkVal(input string tag, input logic [DATA_W-1:0] act,
                          input logic [DATA_W-1:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // All driver tasks start and end on a falling edge
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busWrite(input int a, input logic [DATA_W-1:0] d);
    busWe = 1'b1; busAddr = ADDR_W'(a); busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input int a, input logic [DATA_W-1:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busRe = 1'b1; busAddr = ADDR_W'(a);
    @(negedge clk);
    busRe = 1'b0;
  endtask

  // Monitor: pops the expected item whenever read data is presented
  always @(negedge clk) begin
    if (rstN && busRvalid) begin
      if (expQ.size() == 0) begin
        chkCnt++; errCnt++;
        $display("FAIL R12: unexpected read data 0x%0h expected none", busRdata);
      end else begin
        popExp = expQ.pop_front();
        popTag = tagQ.pop_front();
        checkVal(popTag, busRdata, popExp);
      end
    end
  end

  task automatic finishRun;
    if (expQ.size() != 0) begin
      chkCnt++; errCnt++;
      $display("FAIL R12: %0d reads got no data, expected 0", expQ.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, errCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chkCnt++; errCnt++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 and R13: reset state and constant word
    checkVal("R1 irqOut", DATA_W'(irqOut), 0);
    checkVal("R1 wakeOut", DATA_W'(wakeOut), 0);
    checkVal("R1 padOe", DATA_W'(padOe), 0);
    busRead(A_ID, 32'h21, "R13 id word");
    busRead(A_DIR, 32'hFFFF, "R1 dir reset");
    busRead(A_OUT, 0, "R1 out reset");
    busRead(A_IEN, 0, "R1 irq enable reset");
    busRead(A_WEN, 0, "R1 wake enable reset");
    busRead(A_STAT, 0, "R1 status reset");
    busRead(A_ELO, 0, "R1 edge lo reset");
    idle(1);
    checkVal("R12 valid idle", DATA_W'(busRvalid), 0);

    // R4: data-out aliases
    busWrite(A_OUT, 32'h00F0);
    busWrite(A_OSET, 32'h0003);
    busRead(A_OUT, 32'h00F3, "R4 set alias");
    busWrite(A_OCLR, 32'h0030);
    busRead(A_OUT, 32'h00C3, "R4 clear alias");
    checkVal("R4 padOut", DATA_W'(padOut), 32'h00C3);

    // R3: direction
    busWrite(A_DIR, 32'hFF00);
    checkVal("R3 padOe", DATA_W'(padOe), 32'h00FF);
    busWrite(A_OSET, 32'h0100);
    checkVal("R3 padOe after out write", DATA_W'(padOe), 32'h00FF);
    checkVal("R3 padOut", DATA_W'(padOut), 32'h01C3);

    // R5: enable aliases
    busWrite(A_ISET, 32'h0005);
    busWrite(A_ISET, 32'h0100);
    busWrite(A_ICLR, 32'h0001);
    busRead(A_IEN, 32'h0104, "R5 irq enable aliases");
    busWrite(A_WSET, 32'h0200);
    busWrite(A_WCLR, 32'h0000);
    busRead(A_WEN, 32'h0200, "R5 wake aliases zero clear");
    busWrite(A_IEN, 32'h0000);

    // R6/R7: pin0 rise, pin1 fall, pin2 off, pin3 both, pin9 rise, pin15 fall
    busWrite(A_ELO, 32'h00C6);
    busWrite(A_EHI, 32'h4008);
    padIn = 16'h820F;
    idle(3);
    busRead(A_PIN, 32'h820F, "R2 pin input");
    busRead(A_STAT, 32'h0209, "R6 R7 rising events");
    checkVal("R8 no irq without enable", DATA_W'(irqOut), 0);
    padIn = 16'h0000;
    idle(3);
    busRead(A_STAT, 32'h820B, "R6 R7 falling events R8 sticky");

    // R11: aggregation
    busWrite(A_ISET, 32'h0008);
    checkVal("R11 irqOut", DATA_W'(irqOut), 1);
    checkVal("R11 wakeOut", DATA_W'(wakeOut), 1);

    // R9: write-one-to-clear
    busWrite(A_STAT, 32'h0000);
    busRead(A_STAT, 32'h820B, "R9 zero write");
    busWrite(A_STAT, 32'h0008);
    busRead(A_STAT, 32'h8203, "R9 clear one bit");
    checkVal("R11 irq drops", DATA_W'(irqOut), 0);
    checkVal("R11 wake stays", DATA_W'(wakeOut), 1);
    busWrite(A_STAT, 32'h0200);
    checkVal("R11 wake drops", DATA_W'(wakeOut), 0);

    // R10: rising edge on pin0 lands in the same cycle as its clear
    padIn = 16'h0001;
    idle(2);
    busWrite(A_STAT, 32'h0003);
    busRead(A_STAT, 32'h8001, "R10 set wins over clear");

    // R6: a falling edge on a rising-only pin is ignored
    busWrite(A_STAT, 32'hFFFF);
    padIn = 16'h0000;
    idle(3);
    busRead(A_STAT, 32'h0000, "R6 wrong polarity ignored");
    checkVal("R11 irq idle", DATA_W'(irqOut), 0);
    idle(2);
    finishRun();
  end

endmodule